// File: doc/BRIEF.md
# Packed-Word RAM Key Searcher

The block keeps a table of 32 sixteen-bit keys in a single-port synchronous RAM. Each RAM word holds several keys side by side (two by default), so one read brings several entries at once. All the keys in the fetched word are compared with the search key at the same time. A register beside the RAM holds one valid flag for each entry. An entry only takes part in a search once it has been written.

A search starts when a key is offered on the lookup port while the block is idle. The block then reads the RAM words in rising address order, one per cycle. The compare runs one cycle behind each read. The scan stops at the first word that holds a matching valid entry, or after the last word. The block then gives a one-cycle `done` pulse, together with `hit` and the index of the matching entry.

A write port puts a key into a chosen entry slot and marks that slot valid. Writes are refused while a search is running: `wr_ready` is low during that time. The parameter `LANES` sets how many keys share one word. With 2, 4 or 8 lanes the RAM has 16, 8 or 4 words to scan.

Top module: `keyscan_table`

## Requirements
- R1: After reset `busy`, `done` and `hit` are 0, `wr_ready` is 1, and every entry is invalid, so a search for any key misses. The RAM contents themselves are not cleared by reset.
- R2: A search starts when `lk_start` is 1 while `busy` is 0. `busy` is 1 from the next cycle until `done`. A `lk_start` seen while `busy` is 1 is ignored, and the running search keeps its original key.
- R3: `done` is 1 for exactly one cycle per search. `hit` and `hit_idx` change only at `done`, and they hold their values until the next search completes.
- R4: Say the start is taken at clock edge 0. A match in RAM word r gives `done` after edge r+2. A miss gives `done` after edge ROWS+1, where ROWS = ENTRIES/LANES.
- R5: Entry i sits in RAM word i/LANES, lane i%LANES, with lane l in bits [16l+15:16l]. On a hit, `hit_idx` = word*LANES + lane.
- R6: When several valid entries hold the search key, the one with the lowest index is reported: the lowest word first, then the lowest lane within that word.
- R7: A write sets the valid flag of its entry. An invalid entry never matches, even if the RAM still holds its old key.
- R8: `wr_ready` is 0 while `busy` is 1. A write offered at that time is dropped and changes neither the stored key nor the valid flags.
- R9: A write taken on the same edge as a search start is seen by that search.
- R10: The behaviour above holds for LANES values of 2, 4 and 8 with the derived word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Entry slot to write |
| wr_key | input | 16 | Key to store |
| wr_ready | output | 1 | Write port can accept a write (idle) |
| lk_start | input | 1 | Start a search |
| lk_key | input | 16 | Key to search for |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle search completion pulse |
| hit | output | 1 | Last search found a match |
| hit_idx | output | 5 | Entry index of the match |

## Verification
The assertions take for granted that keys are only ever written through the write port. That means the valid flags can change only on a write that was accepted while idle. Given that, a reported hit can always be checked against the valid flag of the entry it names. The bench keeps to this rule: every write and start is driven on the falling edge, and writes during a search are offered on purpose, to confirm that they are dropped. Every stored key comes from a formula that cannot collide except where duplicates are placed on purpose. So the expected index and latency of each search follow from arithmetic alone. A second instance with eight lanes gets the same stimulus, so that both packings are checked against their own latency formulas.

// File: rtl/keyscan_table.sv
module keyscan_table #(
  parameter int KEY_W   = 16,
  parameter int ENTRIES = 32,
  parameter int LANES   = 2,
  localparam int ROWS   = ENTRIES / LANES,
  localparam int ROW_W  = KEY_W * LANES,
  localparam int AW     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IW     = $clog2(ENTRIES),
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  output logic          wr_ready,
  input  logic          lk_start,
  input  logic [KEY_W-1:0] lk_key,
  output logic          busy,
  output logic          done,
  output logic          hit,
  output logic [IW-1:0] hit_idx
);

  logic [ROW_W-1:0]   mem [ROWS];
  logic [ROW_W-1:0]   rdata;
  logic [ENTRIES-1:0] vld;
  logic [KEY_W-1:0]   key_q;
  logic [AW-1:0]      rd_addr, cmp_row;
  logic               issuing, rd_vld;
  logic [LANES-1:0]   lane_hit;
  logic               m_any;
  logic [LW-1:0]      m_lane;

  wire wr_acc  = wr_en && !busy;
  wire go      = lk_start && !busy;
  wire [AW-1:0] wr_row  = AW'(wr_idx / IW'(LANES));
  wire [LW-1:0] wr_lane = LW'(wr_idx % IW'(LANES));
  wire last_cmp = (cmp_row == AW'(ROWS - 1));
  wire finish   = busy && rd_vld && (m_any || last_cmp);

  assign wr_ready = !busy;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_hit[l] = vld[int'(cmp_row) * LANES + l] &&
                           (rdata[l*KEY_W +: KEY_W] == key_q);
    end
  endgenerate

  always_comb begin
    m_any  = 1'b0;
    m_lane = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (lane_hit[l]) begin
        m_any  = 1'b1;
        m_lane = LW'(l);
      end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_row][int'(wr_lane)*KEY_W +: KEY_W] <= wr_key;
    if (busy && issuing) rdata <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; busy <= 1'b0; issuing <= 1'b0; rd_vld <= 1'b0;
      done <= 1'b0; hit <= 1'b0; hit_idx <= '0;
      rd_addr <= '0; cmp_row <= '0; key_q <= '0;
    end else begin
      done <= 1'b0;
      if (wr_acc) vld[wr_idx] <= 1'b1;
      if (go) begin
        busy <= 1'b1; issuing <= 1'b1; rd_vld <= 1'b0;
        rd_addr <= '0; key_q <= lk_key;
      end else if (busy) begin
        rd_vld  <= issuing;
        cmp_row <= rd_addr;
        if (issuing) begin
          rd_addr <= rd_addr + 1'b1;
          if (rd_addr == AW'(ROWS - 1)) issuing <= 1'b0;
        end
        if (finish) begin
          busy <= 1'b0; issuing <= 1'b0; rd_vld <= 1'b0;
          done <= 1'b1; hit <= m_any;
          hit_idx <= m_any ? IW'(int'(cmp_row) * LANES + int'(m_lane)) : '0;
        end
      end
    end
  end

  logic [AW+1:0] scan_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    scan_cnt <= '0;
    else if (go)   scan_cnt <= '0;
    else if (busy) scan_cnt <= scan_cnt + 1'b1;

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_start && !busy) |=> busy);
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r3_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hit) && $stable(hit_idx)));
  a_r4_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (scan_cnt <= (AW+2)'(ROWS)));
  a_r7_hit_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> vld[hit_idx]);
  a_r8_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(vld));
endmodule

// File: tb/keyscan_table_test.sv
module keyscan_table_test;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, lk_start = 0;
  logic [4:0] wr_idx = 0;
  logic [15:0] wr_key = 0, lk_key = 0;
  logic wr_ready, busy, done, hit, wr_ready8, busy8, done8, hit8;
  logic [4:0] hit_idx, hit_idx8;
  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  keyscan_table #(.LANES(2)) uut (.clk, .rst_n, .wr_en, .wr_idx, .wr_key,
    .wr_ready, .lk_start, .lk_key, .busy, .done, .hit, .hit_idx);
  keyscan_table #(.LANES(8)) uut8 (.clk, .rst_n, .wr_en, .wr_idx, .wr_key,
    .wr_ready(wr_ready8), .lk_start, .lk_key, .busy(busy8), .done(done8),
    .hit(hit8), .hit_idx(hit_idx8));

  function automatic logic [15:0] key_of(int i);
    return 16'(16'h1000 + i * 16'h0101);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic write(int i, logic [15:0] k);
    @(negedge clk) wr_en = 1; wr_idx = 5'(i); wr_key = k;
    @(negedge clk) wr_en = 0;
  endtask

  // wi>=0: write k into entry wi on the start edge; act_at>0: mid-search action
  task automatic lookup(logic [15:0] k, bit eh, int ei, int wi, int act_at,
                        bit act_wr, string tag);
    int n = 0, d2 = -1, d8 = -1;
    int l2 = eh ? ei / 2 + 2 : N / 2 + 1;
    int l8 = eh ? ei / 8 + 2 : N / 8 + 1;
    @(negedge clk) lk_start = 1; lk_key = k;
    if (wi >= 0) begin wr_en = 1; wr_idx = 5'(wi); wr_key = k; end
    @(negedge clk) lk_start = 0; wr_en = 0;
    while ((d2 < 0 || d8 < 0) && n < 60) begin
      if (n == act_at) begin
        check(wr_ready == 0, "R8 wr_ready while busy", int'(wr_ready), 0);
        if (act_wr) begin wr_en = 1; wr_idx = 0; wr_key = k; end
        else begin lk_start = 1; lk_key = key_of(0); end
      end
      @(negedge clk); n++;
      lk_start = 0; wr_en = 0;
      if (done && d2 < 0) d2 = n;
      if (done8 && d8 < 0) d8 = n;
    end
    check(d2 == l2, {tag, " R4 latency"}, d2, l2);
    check(hit == eh, {tag, " R5 hit"}, int'(hit), int'(eh));
    if (eh) check(int'(hit_idx) == ei, {tag, " R5 index"}, int'(hit_idx), ei);
    check(d8 == l8, {tag, " R10 latency x8"}, d8, l8);
    check(hit8 == eh, {tag, " R10 hit x8"}, int'(hit8), int'(eh));
    if (eh) check(int'(hit_idx8) == ei, {tag, " R10 index x8"}, int'(hit_idx8), ei);
    @(negedge clk);
    check(!done && hit == eh, {tag, " R3 pulse and hold"}, int'(done), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    check(!busy && !done && !hit, "R1 reset outputs", int'(busy), 0);
    check(wr_ready == 1, "R1 wr_ready", int'(wr_ready), 1);
    lookup(key_of(3), 0, 0, -1, -1, 0, "R1 empty");
    for (int i = 0; i < N; i++) write(i, key_of(i));
    for (int i = 0; i < N; i++) lookup(key_of(i), 1, i, -1, -1, 0, "R4 sweep");
    lookup(16'hFFFF, 0, 0, -1, -1, 0, "R4 miss");
    // R6: duplicates in one word and across words
    write(7, key_of(6));
    lookup(key_of(6), 1, 6, -1, -1, 0, "R6 same word");
    write(20, key_of(9));
    lookup(key_of(9), 1, 9, -1, -1, 0, "R6 across words");
    // R8: write during search is dropped
    lookup(16'hBEEF, 0, 0, -1, 2, 1, "R8 blocked write");
    lookup(16'hBEEF, 0, 0, -1, -1, 0, "R8 not stored");
    lookup(key_of(0), 1, 0, -1, -1, 0, "R8 entry kept");
    // R2: second start during search ignored
    lookup(key_of(31), 1, 31, -1, 2, 0, "R2 start ignored");
    // R9: write on the start edge is visible
    lookup(16'h7A7A, 1, 2, 2, -1, 0, "R9 same edge");
    // R7: reset drops validity although RAM keeps keys
    do_reset();
    lookup(key_of(5), 0, 0, -1, -1, 0, "R7 invalid");
    write(5, key_of(5));
    lookup(key_of(5), 1, 5, -1, -1, 0, "R7 revalidated");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule